// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block protects one NAND page at a time with a Hamming code that corrects one bit and detects two bits in each 256-byte chunk of data. The page arrives as a byte stream: first all data bytes, then all spare-area bytes. A `start` pulse opens a page and selects one of two modes.

In generate mode the block computes a 3-byte code for every chunk. While the spare bytes stream in, it returns the spare image that must be programmed. That image is 0xFF everywhere except in the last `3*N` bytes, which carry the codes. The spare bytes given at the input are only used for pacing.

In check mode the block recomputes the codes and compares each one with the stored code taken from the spare tail. It then reports one result per chunk: clean, a correctable data bit (with the byte and bit to flip), a single flipped bit inside the stored code, or uncorrectable. The block does not repair the data buffer itself.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset `spare_valid` and `res_valid` are 0. A `start` pulse latches `mode_check` (1 = check, 0 = generate) and opens a page of PAGE_BYTES + SPARE_BYTES bytes. A byte offered in the same cycle as `start` is ignored.
- R2: The code of a chunk is 24 bits. For each address bit j (0..7) of the byte index inside the chunk, bit 2j is the XOR of the byte parities of bytes whose index bit j is 0, and bit 2j+1 is the same for index bit j = 1. For each bit-position bit k (0..2), bit 16+2k is the XOR of all data bits whose position has bit k = 0, and bit 17+2k is the same for bit k = 1. Bits 23:22 are 1.
- R3: In generate mode, each accepted spare input byte produces one `spare_valid` output byte in the next cycle. Spare offsets below SPARE_BYTES−3·N give 0xFF. The value of the spare input bytes has no effect.
- R4: The code of chunk k sits at spare offsets SPARE_BYTES−3·N+3k, +1 and +2, holding code bits 15:8, 7:0 and 23:16 in that order.
- R5: In check mode, one cycle after the third stored-code byte of chunk k is accepted, `res_valid` pulses with `res_chunk`=k. Generate mode never raises `res_valid`, and check mode never raises `spare_valid`.
- R6: A chunk whose stored code equals the recomputed code is reported with class 0 (good).
- R7: If every one of the 11 parity pairs of the syndrome (stored XOR recomputed) has exactly one differing bit and bits 23:22 agree, the class is 1. `res_byte` is then the odd members of the eight line pairs and `res_bit` is the odd members of the three column pairs.
- R8: A syndrome with exactly one set bit (including bits 23:22) gives class 2.
- R9: Any other nonzero syndrome gives class 3. For classes other than 1, `res_byte` and `res_bit` are 0.
- R10: A cycle with `in_valid` low does not advance the stream. Bytes offered after the last spare byte of a page produce no output until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new page |
| mode_check | input | 1 | Mode latched at start: 1 check, 0 generate |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Page data then spare byte |
| spare_valid | output | 1 | Generated spare byte valid |
| spare_byte | output | 8 | Generated spare byte |
| res_valid | output | 1 | Chunk result valid |
| res_chunk | output | CK_W | Chunk index of the result |
| res_class | output | 2 | 0 good, 1 data bit fixed, 2 code bit, 3 uncorrectable |
| res_byte | output | 8 | Byte offset inside the chunk to flip |
| res_bit | output | 3 | Bit position to flip |

## Verification
A generated spare byte is due exactly one clock after the edge that accepts the matching spare input byte. A chunk result is due one clock after the edge that accepts the third code byte of that chunk. The bench drives inputs on the falling edge and captures every valid output on the next falling edge, so each capture lands in its due cycle whatever the input gaps. After each page it compares the count, order and content of the captures with values computed from the injected error pattern.

// File: rtl/nand_page_ecc_pkg.sv
package nand_page_ecc_pkg;

    localparam int CHUNK_BYTES = 256;
    localparam int PAR_W       = 22;
    localparam int CODE_W      = 24;

    typedef enum logic [1:0] {
        CLS_GOOD     = 2'd0,
        CLS_DATA_FIX = 2'd1,
        CLS_CODE_BIT = 2'd2,
        CLS_BAD      = 2'd3
    } chunk_class_e;

    typedef struct packed {
        chunk_class_e cls;
        logic [7:0]   byte_idx;
        logic [2:0]   bit_idx;
    } fix_info_t;

endpackage

// File: rtl/ecc_chunk_parity.sv
module ecc_chunk_parity
    import nand_page_ecc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [7:0]          byte_idx,
    input  logic [7:0]          data,
    output logic [CODE_W-1:0]   code_o
);
    logic [PAR_W-1:0] par_q, par_d, par_next;
    logic             bpar;

    always_comb begin
        par_next = (byte_idx == 8'd0) ? '0 : par_q;
        bpar     = ^data;
        for (int j = 0; j < 8; j++) begin
            if (byte_idx[j]) par_next[2*j+1] = par_next[2*j+1] ^ bpar;
            else             par_next[2*j]   = par_next[2*j]   ^ bpar;
        end
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < 3; k++) begin
                if (b[k]) par_next[17+2*k] = par_next[17+2*k] ^ data[b];
                else      par_next[16+2*k] = par_next[16+2*k] ^ data[b];
            end
        end
        par_d  = en ? par_next : par_q;
        code_o = {2'b11, par_next};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    // R2: after the first byte of a chunk no odd line parity can be set
    p_first_byte_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && byte_idx == 8'd0) |-> ((par_q[15:0] & 16'hAAAA) == 16'h0000));

endmodule

// File: rtl/ecc_code_store.sv
module ecc_code_store
    import nand_page_ecc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [CODE_W-1:0] rdata
);
    logic [CODE_W-1:0] mem_q [DEPTH];
    logic [CODE_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = (we && (int'(waddr) == i)) ? wdata : mem_q[i];
        end
        rdata = mem_q[raddr];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '1;
            else        mem_q[i] <= mem_d[i];
        end
    end

endmodule

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
    import nand_page_ecc_pkg::*;
(
    input  logic [CODE_W-1:0] syn_i,
    output fix_info_t         info_o
);
    logic [10:0] pair_hit;
    int unsigned weight;

    always_comb begin
        weight = 0;
        for (int i = 0; i < CODE_W; i++) weight = weight + int'(syn_i[i]);
        for (int p = 0; p < 11; p++) pair_hit[p] = syn_i[2*p] ^ syn_i[2*p+1];

        info_o = '{cls: CLS_GOOD, byte_idx: 8'd0, bit_idx: 3'd0};
        if (syn_i == '0) begin
            info_o.cls = CLS_GOOD;
        end else if ((&pair_hit) && (syn_i[23:22] == 2'b00)) begin
            info_o.cls = CLS_DATA_FIX;
            for (int j = 0; j < 8; j++) info_o.byte_idx[j] = syn_i[2*j+1];
            for (int k = 0; k < 3; k++) info_o.bit_idx[k]  = syn_i[17+2*k];
        end else if (weight == 1) begin
            info_o.cls = CLS_CODE_BIT;
        end else begin
            info_o.cls = CLS_BAD;
        end
    end

    // R7: a correctable data bit always shows as eleven differing bits
    always_comb begin
        if (!$isunknown(syn_i) && info_o.cls == CLS_DATA_FIX)
            p_fix_weight_r7: assert ($countones(syn_i) == 11);
    end

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
    import nand_page_ecc_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    localparam int NCHUNK     = PAGE_BYTES / CHUNK_BYTES,
    localparam int CK_W       = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            mode_check,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    output logic            spare_valid,
    output logic [7:0]      spare_byte,
    output logic            res_valid,
    output logic [CK_W-1:0] res_chunk,
    output logic [1:0]      res_class,
    output logic [7:0]      res_byte,
    output logic [2:0]      res_bit
);
    localparam int CODE_BYTES = 3 * NCHUNK;
    localparam int TOTAL      = PAGE_BYTES + SPARE_BYTES;
    localparam int CODE_POS   = TOTAL - CODE_BYTES;
    localparam int POS_W      = $clog2(TOTAL + 1);

    typedef struct packed {
        logic            active;
        logic            chk_mode;
        logic [POS_W-1:0] pos;
        logic [1:0]      tri_idx;
        logic [CK_W-1:0] ck;
        logic [7:0]      hold_mid;
        logic [7:0]      hold_low;
        logic            spare_valid;
        logic [7:0]      spare_byte;
        logic            res_valid;
        logic [CK_W-1:0] res_chunk;
        fix_info_t       res_info;
    } state_t;

    state_t q, d;

    logic              acc_en;
    logic              st_we;
    logic [CODE_W-1:0] code_now;
    logic [CODE_W-1:0] st_rdata;
    logic [CODE_W-1:0] syn;
    fix_info_t         dec_info;
    logic              is_data;
    logic              in_code;

    ecc_chunk_parity u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (acc_en),
        .byte_idx (q.pos[7:0]),
        .data     (in_byte),
        .code_o   (code_now)
    );

    ecc_code_store #(.DEPTH(NCHUNK), .AW(CK_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (q.pos[8 +: CK_W]),
        .wdata (code_now),
        .raddr (q.ck),
        .rdata (st_rdata)
    );

    assign syn = {in_byte, q.hold_mid, q.hold_low} ^ st_rdata;

    ecc_syndrome_decode u_dec (
        .syn_i  (syn),
        .info_o (dec_info)
    );

    always_comb begin
        d             = q;
        d.spare_valid = 1'b0;
        d.res_valid   = 1'b0;
        acc_en        = 1'b0;
        st_we         = 1'b0;
        is_data       = q.pos < POS_W'(PAGE_BYTES);
        in_code       = q.pos >= POS_W'(CODE_POS);

        if (start) begin
            d.active   = 1'b1;
            d.chk_mode = mode_check;
            d.pos      = '0;
            d.tri_idx  = 2'd0;
            d.ck       = '0;
        end else if (q.active && in_valid) begin
            d.pos = q.pos + 1'b1;
            if (q.pos == POS_W'(TOTAL - 1)) d.active = 1'b0;
            if (is_data) begin
                acc_en = 1'b1;
                st_we  = (q.pos[7:0] == 8'hFF);
            end else begin
                if (in_code) begin
                    if (q.tri_idx == 2'd2) begin
                        d.tri_idx = 2'd0;
                        d.ck      = q.ck + 1'b1;
                    end else begin
                        d.tri_idx = q.tri_idx + 2'd1;
                    end
                end
                if (!q.chk_mode) begin
                    d.spare_valid = 1'b1;
                    if (!in_code)              d.spare_byte = 8'hFF;
                    else if (q.tri_idx == 2'd0) d.spare_byte = st_rdata[15:8];
                    else if (q.tri_idx == 2'd1) d.spare_byte = st_rdata[7:0];
                    else                        d.spare_byte = st_rdata[23:16];
                end else if (in_code) begin
                    if (q.tri_idx == 2'd0)      d.hold_mid = in_byte;
                    else if (q.tri_idx == 2'd1) d.hold_low = in_byte;
                    else begin
                        d.res_valid = 1'b1;
                        d.res_chunk = q.ck;
                        d.res_info  = dec_info;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign spare_valid = q.spare_valid;
    assign spare_byte  = q.spare_byte;
    assign res_valid   = q.res_valid;
    assign res_chunk   = q.res_chunk;
    assign res_class   = q.res_info.cls;
    assign res_byte    = q.res_info.byte_idx;
    assign res_bit     = q.res_info.bit_idx;

    // R3: generated spare bytes follow an accepted spare byte in generate mode
    p_spare_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spare_valid |-> $past(q.active && in_valid && !start && !q.chk_mode
                              && q.pos >= POS_W'(PAGE_BYTES)));

    // R3: bytes ahead of the code tail are filler
    p_spare_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_valid && $past(q.pos < POS_W'(CODE_POS))) |-> spare_byte == 8'hFF);

    // R5: results only follow the last byte of a stored code in check mode
    p_res_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(q.active && in_valid && !start && q.chk_mode
                            && q.tri_idx == 2'd2 && q.pos >= POS_W'(CODE_POS)));

    // R9: a location is reported only for a correctable data bit
    p_loc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class != 2'd1) |-> (res_byte == 8'd0 && res_bit == 3'd0));

    // R10: an idle input cycle keeps the stream position
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !in_valid && !start) |=> $stable(q.pos));

endmodule

// File: tb/nand_page_ecc_test.sv
module nand_page_ecc_test;
    localparam int PAGE  = 2048;
    localparam int SPARE = 64;
    localparam int NCH   = PAGE / 256;
    localparam int TOTAL = PAGE + SPARE;
    localparam int CPOS  = SPARE - 3 * NCH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode_check = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       spare_valid;
    logic [7:0] spare_byte;
    logic       res_valid;
    logic [2:0] res_chunk;
    logic [1:0] res_class;
    logic [7:0] res_byte;
    logic [2:0] res_bit;

    always #4 clk = ~clk;

    nand_page_ecc #(.PAGE_BYTES(PAGE), .SPARE_BYTES(SPARE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_check(mode_check),
        .in_valid(in_valid), .in_byte(in_byte),
        .spare_valid(spare_valid), .spare_byte(spare_byte),
        .res_valid(res_valid), .res_chunk(res_chunk), .res_class(res_class),
        .res_byte(res_byte), .res_bit(res_bit)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] page_mem [PAGE];
    logic [7:0] stream   [TOTAL];
    logic [7:0] cap_sp   [SPARE + 8];
    int         cap_ck   [NCH + 4];
    int         cap_cls  [NCH + 4];
    int         cap_byte [NCH + 4];
    int         cap_bit  [NCH + 4];
    int         exp_cls  [NCH];
    int         exp_byte [NCH];
    int         exp_bit  [NCH];
    int         n_sp = 0;
    int         n_res = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spare_valid) begin
                if (n_sp < SPARE + 8) cap_sp[n_sp] = spare_byte;
                n_sp = n_sp + 1;
            end
            if (res_valid) begin
                if (n_res < NCH + 4) begin
                    cap_ck[n_res]   = int'(res_chunk);
                    cap_cls[n_res]  = int'(res_class);
                    cap_byte[n_res] = int'(res_byte);
                    cap_bit[n_res]  = int'(res_bit);
                end
                n_res = n_res + 1;
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // R2 code definition
    function automatic logic [23:0] ref_code(input int ck);
        logic [21:0] p = '0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b = page_mem[ck * 256 + i];
            for (int j = 0; j < 8; j++) begin
                if (i[j]) p[2*j+1] ^= ^b;
                else      p[2*j]   ^= ^b;
            end
            for (int bt = 0; bt < 8; bt++) begin
                for (int k = 0; k < 3; k++) begin
                    if (bt[k]) p[17+2*k] ^= b[bt];
                    else       p[16+2*k] ^= b[bt];
                end
            end
        end
        return {2'b11, p};
    endfunction

    // R3/R4 spare image
    function automatic logic [7:0] exp_spare(input int s);
        logic [23:0] c;
        int r;
        if (s < CPOS) return 8'hFF;
        r = s - CPOS;
        c = ref_code(r / 3);
        case (r % 3)
            0:       return c[15:8];
            1:       return c[7:0];
            default: return c[23:16];
        endcase
    endfunction

    task automatic build_stream(input bit rand_spare);
        for (int i = 0; i < PAGE; i++) stream[i] = page_mem[i];
        for (int s = 0; s < SPARE; s++)
            stream[PAGE + s] = rand_spare ? 8'($urandom) : exp_spare(s);
        for (int k = 0; k < NCH; k++) begin
            exp_cls[k] = 0; exp_byte[k] = 0; exp_bit[k] = 0;
        end
    endtask

    task automatic feed(input bit chk, input bit gaps);
        n_sp  = 0;
        n_res = 0;
        @(negedge clk);
        start      = 1'b1;
        mode_check = chk;
        in_valid   = 1'b1;          // R1: byte in the start cycle is ignored
        in_byte    = 8'($urandom);
        @(negedge clk);
        start    = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < TOTAL; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
                repeat (1 + $urandom % 3) @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = stream[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_spare(input string tag);
        check({tag, " R3 spare count"}, n_sp, SPARE);
        check({tag, " R5 no result in generate mode"}, n_res, 0);
        for (int s = 0; s < SPARE && s < n_sp; s++)
            check((s < CPOS) ? {tag, " R3 filler"} : {tag, " R4 code byte"},
                  int'(cap_sp[s]), int'(exp_spare(s)));
    endtask

    task automatic check_results(input string tag);
        check({tag, " R5 result count"}, n_res, NCH);
        check({tag, " R5 no spare in check mode"}, n_sp, 0);
        for (int k = 0; k < NCH && k < n_res; k++) begin
            check({tag, " R5 chunk order"}, cap_ck[k], k);
            case (exp_cls[k])
                0: check({tag, " R6 class"}, cap_cls[k], 0);
                1: check({tag, " R7 class"}, cap_cls[k], 1);
                2: check({tag, " R8 class"}, cap_cls[k], 2);
                default: check({tag, " R9 class"}, cap_cls[k], 3);
            endcase
            check((exp_cls[k] == 1) ? {tag, " R7 byte"} : {tag, " R9 byte zero"},
                  cap_byte[k], exp_byte[k]);
            check((exp_cls[k] == 1) ? {tag, " R7 bit"} : {tag, " R9 bit zero"},
                  cap_bit[k], exp_bit[k]);
        end
    endtask

    task automatic flip_data(input int ck, input int by, input int bt);
        stream[ck * 256 + by][bt] = ~stream[ck * 256 + by][bt];
    endtask

    task automatic flip_code(input int ck, input int pos, input int bt);
        stream[PAGE + CPOS + 3 * ck + pos][bt] = ~stream[PAGE + CPOS + 3 * ck + pos][bt];
    endtask

    initial begin
        int seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 spare_valid after reset", int'(spare_valid), 0);
        check("R1 res_valid after reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle spare_valid", int'(spare_valid), 0);

        // generate mode, random data, random spare input (R3 ignored)
        for (int i = 0; i < PAGE; i++) page_mem[i] = 8'($urandom);
        build_stream(1'b1);
        feed(1'b0, 1'b0);
        check_spare("gen-random");

        // R10: bytes after page end give nothing
        n_sp = 0;
        in_valid = 1'b1;
        repeat (6) @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 nothing after page end", n_sp + n_res, 0);

        // clean read with stalls
        build_stream(1'b0);
        feed(1'b1, 1'b1);
        check_results("clean");

        // single data bit errors at boundaries and middle
        build_stream(1'b0);
        flip_data(0, 0, 0);     exp_cls[0] = 1; exp_byte[0] = 0;   exp_bit[0] = 0;
        flip_data(3, 90, 6);    exp_cls[3] = 1; exp_byte[3] = 90;  exp_bit[3] = 6;
        flip_data(7, 255, 7);   exp_cls[7] = 1; exp_byte[7] = 255; exp_bit[7] = 7;
        feed(1'b1, 1'b0);
        check_results("data-bit");

        // single stored-code bit errors, incl. unused bit 23
        build_stream(1'b0);
        flip_code(1, 0, 3); exp_cls[1] = 2;
        flip_code(4, 2, 7); exp_cls[4] = 2;
        flip_code(6, 1, 0); exp_cls[6] = 2;
        feed(1'b1, 1'b1);
        check_results("code-bit");

        // double errors
        build_stream(1'b0);
        flip_data(2, 10, 1); flip_data(2, 200, 5); exp_cls[2] = 3;
        flip_data(5, 17, 4); flip_code(5, 1, 2);   exp_cls[5] = 3;
        flip_data(6, 33, 2); flip_data(6, 33, 3);  exp_cls[6] = 3;
        feed(1'b1, 1'b0);
        check_results("double");

        // constant pages in generate mode with stalls
        for (int i = 0; i < PAGE; i++) page_mem[i] = 8'hFF;
        build_stream(1'b1);
        feed(1'b0, 1'b1);
        check_spare("gen-ones");
        for (int i = 0; i < PAGE; i++) page_mem[i] = 8'h00;
        build_stream(1'b0);
        feed(1'b0, 1'b0);
        check_spare("gen-zeros");

        // random pages with random error kinds per chunk
        for (int pg = 0; pg < 5; pg++) begin
            for (int i = 0; i < PAGE; i++) page_mem[i] = 8'($urandom);
            build_stream(1'b0);
            for (int k = 0; k < NCH; k++) begin
                int kind = int'($urandom % 4);
                int by = int'($urandom % 256);
                int bt = int'($urandom % 8);
                if (kind == 1) begin
                    flip_data(k, by, bt);
                    exp_cls[k] = 1; exp_byte[k] = by; exp_bit[k] = bt;
                end else if (kind == 2) begin
                    flip_code(k, int'($urandom % 3), bt);
                    exp_cls[k] = 2;
                end else if (kind == 3) begin
                    flip_data(k, by, bt);
                    flip_data(k, (by + 1 + int'($urandom % 255)) % 256, int'($urandom % 8));
                    exp_cls[k] = 3;
                end
            end
            feed(1'b1, pg[0]);
            check_results("random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule